// File: doc/BRIEF.md
# Oversampling Serial Receiver with Sticky Error Flags

The block receives asynchronous serial characters on a single input line and assembles 8-bit values. It is clocked by the system clock and advances only on a clock enable pulsed at sixteen times the bit rate. A falling edge on the idle-high line is treated as a candidate start bit. After confirmation, every later bit is sampled once, near its centre. Each frame can carry an optional even or odd parity bit, and the frame can end with one or two stop bits.

A finished character always goes into a data holding register. Three sticky flags report the result: data-full, framing error and parity error. Software clears a flag with a two-step handshake. It first reads the status while the flag is 1, then writes 0 to that flag's bit. While either error flag is set, the receiver ignores the line. The data register and the data-full flag then stay frozen until software has acknowledged the error.

Top module: `uart_rx_sticky`

## Requirements
- R1: A low level seen on a baud tick starts a candidate start bit. The line is checked again 8 ticks later. If it is high then, the candidate is dropped and nothing is loaded. Otherwise the 8 data bits arrive LSB first, and each is sampled 16 ticks after the previous sample.
- R2: A character with no error is written to `rx_data`, and the data-full flag (`rx_status[0]`) becomes 1.
- R3: When `par_en` is 1, a parity bit follows the data. The parity error flag (`rx_status[2]`) sets if the number of 1s in data plus parity bit is odd while `par_odd`=0, or even while `par_odd`=1.
- R4: The framing error flag (`rx_status[1]`) sets when the first stop bit is sampled as 0. When `two_stop`=1, the value of the second stop bit is never checked.
- R5: On a framing or parity error, the character is still written to `rx_data`, but the data-full flag stays 0.
- R6: While the framing or parity error flag is 1, no character is accepted, and `rx_data` and the data-full flag do not change.
- R7: A status flag clears only on a write with its `stat_wdata` bit at 0, and only if a status read saw that flag at 1 after the previous write. A write of 0 without such a read has no effect, and so does a write of 1.
- R8: While `rx_enable`=0, no character is received. Changing `rx_enable` does not change either error flag.
- R9: If a flag is set by a finished character in the same cycle as a valid clear write, the flag stays 1.
- R10: After reset, all three flags and `rx_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | Clock enable at 16 times the bit rate |
| rx_in | input | 1 | Serial line, idle high |
| rx_enable | input | 1 | Receive enable |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| two_stop | input | 1 | 1 = two stop bits |
| stat_rd | input | 1 | Status read strobe (arms clearing of flags seen at 1) |
| stat_wr | input | 1 | Status write strobe |
| stat_wdata | input | 3 | Write data; a 0 bit clears an armed flag |
| rx_data | output | 8 | Receive data register |
| rx_status | output | 3 | {parity error, framing error, data-full} |

## Verification
The hardest case to reach from the ports is R9. A clear write must land on exactly the clock edge where a finished character sets the data-full flag. The stimulus first sends a reference frame with the baud phase locked, and measures how many cycles pass from the start bit until data-full is seen. It then arms the flag and sends an identical frame. The clear write is placed on the measured edge, so set and clear collide.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int DATA_W    = 8;
    localparam int OSR       = 16;
    localparam int CNT_W     = $clog2(OSR);
    localparam int BIT_W     = $clog2(DATA_W);

    localparam int FLAG_N    = 3;
    localparam int FLAG_FULL = 0;
    localparam int FLAG_FER  = 1;
    localparam int FLAG_PER  = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_STOP2
    } rx_state_e;

    typedef struct packed {
        logic par_en;
        logic par_odd;
        logic two_stop;
    } rx_mode_t;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              fer;
        logic              per;
    } rx_result_t;

    function automatic logic parity_bad(input logic [DATA_W-1:0] d,
                                        input logic pbit,
                                        input logic odd);
        return (^{d, pbit}) != odd;
    endfunction

endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/rx_frame.sv
module rx_frame
    import uart_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       rx,
    input  logic       en,
    input  logic       lock,
    input  rx_mode_t   mode,
    output logic       done,
    output rx_result_t result
);
    localparam int HALF = OSR / 2;

    rx_state_e         state;
    logic [CNT_W-1:0]  cnt;
    logic [BIT_W-1:0]  nbit;
    logic [DATA_W-1:0] sh;
    logic              pbit;
    rx_mode_t          mode_q;

    wire at_mid  = (cnt == CNT_W'(HALF - 1));
    wire at_full = (cnt == CNT_W'(OSR - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            nbit   <= '0;
            sh     <= '0;
            pbit   <= 1'b0;
            mode_q <= '0;
            done   <= 1'b0;
            result <= '0;
        end else begin
            done <= 1'b0;
            if (!en && state != ST_IDLE) begin
                state <= ST_IDLE;
                cnt   <= '0;
            end else if (tick) begin
                unique case (state)
                    ST_IDLE: begin
                        if (en && !lock && !rx) begin
                            state <= ST_START;
                            cnt   <= '0;
                        end
                    end
                    ST_START: begin
                        if (at_mid) begin
                            cnt <= '0;
                            if (!rx) begin
                                state  <= ST_DATA;
                                nbit   <= '0;
                                mode_q <= mode;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        if (at_full) begin
                            cnt <= '0;
                            sh  <= {rx, sh[DATA_W-1:1]};
                            if (nbit == BIT_W'(DATA_W - 1))
                                state <= mode_q.par_en ? ST_PAR : ST_STOP;
                            else
                                nbit <= nbit + 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_PAR: begin
                        if (at_full) begin
                            cnt   <= '0;
                            pbit  <= rx;
                            state <= ST_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_STOP: begin
                        if (at_full) begin
                            cnt         <= '0;
                            done        <= 1'b1;
                            result.data <= sh;
                            result.fer  <= !rx;
                            result.per  <= mode_q.par_en && parity_bad(sh, pbit, mode_q.par_odd);
                            state       <= mode_q.two_stop ? ST_STOP2 : ST_IDLE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_STOP2: begin
                        if (at_full) begin
                            if (rx) state <= ST_IDLE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // R6
    lock_holds_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && lock) |=> state == ST_IDLE);

    // R8
    disabled_no_done_chk: assert property (@(posedge clk) disable iff (rst)
        (!en && state == ST_IDLE) |=> !done);
endmodule

// File: rtl/rx_flag.sv
module rx_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic rd,
    input  logic wr,
    input  logic wbit,
    output logic flag
);
    logic armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag  <= 1'b0;
            armed <= 1'b0;
        end else begin
            if (set)
                flag <= 1'b1;
            else if (wr && armed && !wbit)
                flag <= 1'b0;

            if (wr)
                armed <= 1'b0;
            else if (rd && flag)
                armed <= 1'b1;
        end
    end

    // R7
    clear_needs_arm_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(flag) |-> $past(armed && wr && !wbit));

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        set |=> flag);
endmodule

// File: rtl/uart_rx_sticky.sv
module uart_rx_sticky
    import uart_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              baud_tick,
    input  logic              rx_in,
    input  logic              rx_enable,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              two_stop,
    input  logic              stat_rd,
    input  logic              stat_wr,
    input  logic [FLAG_N-1:0] stat_wdata,
    output logic [DATA_W-1:0] rx_data,
    output logic [FLAG_N-1:0] rx_status
);
    logic       rx_s;
    logic       done;
    rx_result_t res;
    rx_mode_t   mode;
    logic       lock;
    logic [FLAG_N-1:0] set_vec;

    assign mode = '{par_en: par_en, par_odd: par_odd, two_stop: two_stop};
    assign lock = rx_status[FLAG_FER] | rx_status[FLAG_PER];

    rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (rx_in),
        .dout (rx_s)
    );

    rx_frame u_frame (
        .clk    (clk),
        .rst    (rst),
        .tick   (baud_tick),
        .rx     (rx_s),
        .en     (rx_enable),
        .lock   (lock),
        .mode   (mode),
        .done   (done),
        .result (res)
    );

    always_ff @(posedge clk) begin
        if (rst)       rx_data <= '0;
        else if (done) rx_data <= res.data;
    end

    always_comb begin
        set_vec            = '0;
        set_vec[FLAG_FULL] = done && !res.fer && !res.per;
        set_vec[FLAG_FER]  = done && res.fer;
        set_vec[FLAG_PER]  = done && res.per;
    end

    for (genvar gi = 0; gi < FLAG_N; gi++) begin : g_flag
        rx_flag u_flag (
            .clk  (clk),
            .rst  (rst),
            .set  (set_vec[gi]),
            .rd   (stat_rd),
            .wr   (stat_wr),
            .wbit (stat_wdata[gi]),
            .flag (rx_status[gi])
        );
    end

    // R5
    full_only_clean_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_status[FLAG_FULL]) |-> !$rose(rx_status[FLAG_FER]) && !$rose(rx_status[FLAG_PER]));

    // R6
    data_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        $past(lock) |-> $stable(rx_data));

    // R8
    err_kept_chk: assert property (@(posedge clk) disable iff (rst)
        !stat_wr |=> !$fell(rx_status[FLAG_FER]) && !$fell(rx_status[FLAG_PER]));

    // R10
    reset_state_chk: assert property (@(posedge clk)
        $past(rst) |-> (rx_status == '0 && rx_data == '0));
endmodule

// File: tb/test_uart_rx_sticky.sv
module test_uart_rx_sticky;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 4;
    localparam int BITCYC     = 16 * DIV;

    typedef struct {
        logic [7:0] data;
        logic [2:0] stat;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       baud_tick;
    logic       rx_in = 1'b1;
    logic       rx_enable = 1'b1;
    logic       par_en = 1'b0, par_odd = 1'b0, two_stop = 1'b0;
    logic       stat_rd = 1'b0, stat_wr = 1'b0;
    logic [2:0] stat_wdata = 3'b111;
    logic [7:0] rx_data;
    logic [2:0] rx_status;

    int   cyc = 0;
    int   frame_cnt = 0;
    int   n_chk = 0, n_fail = 0;
    exp_t q[$];

    logic [7:0] m_data = 8'h00;
    logic [2:0] m_flag = 3'b000;
    logic [2:0] m_arm  = 3'b000;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    assign baud_tick = (cyc % DIV) == 0;

    uart_rx_sticky i_uart_rx_sticky (
        .clk(clk), .rst(rst), .baud_tick(baud_tick), .rx_in(rx_in),
        .rx_enable(rx_enable), .par_en(par_en), .par_odd(par_odd),
        .two_stop(two_stop), .stat_rd(stat_rd), .stat_wr(stat_wr),
        .stat_wdata(stat_wdata), .rx_data(rx_data), .rx_status(rx_status)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_state(input string tag);
        chk({tag, " status"}, 32'(rx_status), 32'(m_flag));
        chk({tag, " data"}, 32'(rx_data), 32'(m_data));
    endtask

    task automatic drive_bit(input logic b);
        rx_in = b;
        repeat (BITCYC) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input logic pen, input logic podd,
                              input logic pbad, input logic stop1, input logic two,
                              input logic stop2, input string tag);
        logic fer, per;
        par_en = pen; par_odd = podd; two_stop = two;
        @(negedge clk);
        while (cyc % DIV != 0) @(negedge clk);
        frame_cnt++;
        drive_bit(1'b0);
        for (int i = 0; i < 8; i++) drive_bit(d[i]);
        if (pen) drive_bit(^d ^ podd ^ pbad);
        drive_bit(stop1);
        if (two) drive_bit(stop2);
        rx_in = 1'b1;
        repeat (20 * DIV) @(negedge clk);
        if (rx_enable && !m_flag[1] && !m_flag[2]) begin
            fer = !stop1;
            per = pen && pbad;
            m_data = d;
            if (fer) m_flag[1] = 1'b1;
            if (per) m_flag[2] = 1'b1;
            if (!fer && !per) m_flag[0] = 1'b1;
        end
        q.push_back('{data: m_data, stat: m_flag, tag: tag});
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic do_read();
        @(negedge clk); stat_rd = 1'b1;
        @(negedge clk); stat_rd = 1'b0;
        m_arm = m_arm | m_flag;
    endtask

    task automatic do_write(input logic [2:0] w);
        @(negedge clk); stat_wr = 1'b1; stat_wdata = w;
        @(negedge clk); stat_wr = 1'b0; stat_wdata = 3'b111;
        m_flag = m_flag & ~(m_arm & ~w);
        m_arm  = 3'b000;
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            exp_t e;
            wait (q.size() > 0);
            e = q.pop_front();
            chk({e.tag, " data"}, 32'(rx_data), 32'(e.data));
            chk({e.tag, " status"}, 32'(rx_status), 32'(e.stat));
        end
    end

    initial begin
        repeat (200000 / 2) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        int k;
        int f0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk_state("R10 reset");

        // R1 R2 plain 8-bit frame
        send_frame(8'h55, 0, 0, 0, 1, 0, 1, "R1 R2 8N1 0x55");
        do_read(); do_write(3'b000);
        chk_state("R7 clear after read");

        // R7 write without read, write of one
        send_frame(8'hA3, 0, 0, 0, 1, 0, 1, "R2 8N1 0xA3");
        do_write(3'b000);
        chk_state("R7 unarmed write ignored");
        do_read(); do_write(3'b111);
        chk_state("R7 write one ignored");
        do_read(); do_write(3'b110);
        chk_state("R7 clear full only");

        // R3 even parity good then bad
        send_frame(8'h3C, 1, 0, 0, 1, 0, 1, "R3 even good");
        do_read(); do_write(3'b000);
        send_frame(8'h3C, 1, 0, 1, 1, 0, 1, "R3 R5 even bad");
        send_frame(8'h81, 0, 0, 0, 1, 0, 1, "R6 locked by parity error");
        do_read(); do_write(3'b000);
        chk_state("R7 parity flag cleared");

        // R3 odd parity
        send_frame(8'h07, 1, 1, 0, 1, 0, 1, "R3 odd good");
        do_read(); do_write(3'b000);
        send_frame(8'h07, 1, 1, 1, 1, 0, 1, "R3 R5 odd bad");
        do_read(); do_write(3'b000);

        // R4 R5 framing error, R8 enable
        send_frame(8'hC5, 0, 0, 0, 0, 0, 1, "R4 R5 bad stop");
        rx_enable = 1'b0;
        repeat (8) @(negedge clk);
        chk_state("R8 disable keeps framing flag");
        rx_enable = 1'b1;
        repeat (8) @(negedge clk);
        chk_state("R8 enable keeps framing flag");
        do_read(); do_write(3'b000);
        rx_enable = 1'b0;
        send_frame(8'h6E, 0, 0, 0, 1, 0, 1, "R8 disabled no receive");
        rx_enable = 1'b1;

        // R4 two stops: second not checked, first checked
        send_frame(8'h96, 0, 0, 0, 1, 1, 0, "R4 second stop low ignored");
        do_read(); do_write(3'b000);
        repeat (40 * DIV) @(negedge clk);
        chk_state("R4 no stray char after second stop");
        send_frame(8'h4B, 0, 0, 0, 0, 1, 1, "R4 first stop low two-stop");
        do_read(); do_write(3'b000);

        // R1 short glitch is not a start bit
        @(negedge clk);
        while (cyc % DIV != 0) @(negedge clk);
        rx_in = 1'b0;
        repeat (3 * DIV) @(negedge clk);
        rx_in = 1'b1;
        repeat (40 * DIV) @(negedge clk);
        chk_state("R1 glitch rejected");

        // R9 set versus clear in the same cycle
        f0 = frame_cnt;
        k  = 0;
        fork
            send_frame(8'h2D, 0, 0, 0, 1, 0, 1, "R9 reference frame");
            begin
                wait (frame_cnt == f0 + 1);
                do begin
                    @(negedge clk);
                    k++;
                end while (!rx_status[0]);
            end
        join
        do_read();
        fork
            send_frame(8'hD2, 0, 0, 0, 1, 0, 1, "R9 collided frame");
            begin
                wait (frame_cnt == f0 + 2);
                repeat (k - 1) @(negedge clk);
                stat_wr = 1'b1; stat_wdata = 3'b000;
                @(negedge clk);
                stat_wr = 1'b0; stat_wdata = 3'b111;
            end
        join
        m_arm = 3'b000;
        chk("R9 set beats clear", 32'(rx_status[0]), 32'd1);
        do_write(3'b000);
        chk_state("R9 flag kept after disarmed write");

        wait (q.size() == 0);
        @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule